// File: doc/BRIEF.md
# Dual-Strobe Burst Address Generator

This block turns a captured word address into the sequence of array addresses for a four-beat burst. A burst opens when one of two active-low address strobes is acted on at a rising clock edge. One strobe comes from the processor and the other from a cache controller. The block then registers the upper address bits and loads the two low bits into a wraparound counter. Each later edge with the advance input low moves the counter one step. A static order select chooses the low-bit walk: either a modular increment or an exclusive-OR of the start value with the step count.

Three chip enables qualify every strobe: one active-low enable, one active-high enable and a second active-low enable. The processor strobe is dropped whenever the first active-low enable is high. When the enables are not all active, a strobe that is acted on deselects the block instead of loading. A status output shows whether the block is selected. A one-cycle flag marks the first address of a new burst. A further output records which strobe loaded the current burst.

Top module: `burst_addr_gen`

## Requirements
- R1: While reset is low and on the first cycle after it, `array_addr_o` is 0 and `active_o`, `burst_start_o` and `cpu_src_o` are all 0.
- R2: A processor strobe (`strobe_cpu_n` low) with `ce_a_n` low, `ce_b` high and `ce_c_n` low at an edge has visible effects after that edge. `array_addr_o` equals the sampled `addr_i`, `active_o` is 1, `burst_start_o` is 1 and `cpu_src_o` is 1.
- R3: When both strobes are low and `ce_a_n` is low, only the processor strobe is acted on. `cpu_src_o` reads 1 after a load made this way.
- R4: With `ce_a_n` high, the processor strobe is ignored. If `strobe_ctl_n` is also high, every output holds its value. If `strobe_ctl_n` is low, the controller strobe is acted on.
- R5: A strobe that is acted on while the three enables are not all active clears `active_o` and `burst_start_o`. It leaves `array_addr_o` and `cpu_src_o` unchanged.
- R6: With no strobe acted on, `advance_n` low and `active_o` 1, the counter steps once per edge. After four steps the low bits return to their start value.
- R7: `advance_n` has no effect at an edge where a strobe loads a new address. The low bits then equal `addr_i[1:0]`.
- R8: With `order_sel` 0 (linear), the low bits on step k equal (start + k) mod 4. For example, start 2'b10 gives 10, 11, 00, 01.
- R9: With `order_sel` 1 (interleaved), the low bits on step k equal start XOR k. For example, start 2'b01 gives 01, 00, 11, 10.
- R10: `array_addr_o[16:2]` stays equal to the loaded `addr_i[16:2]` for the whole burst.
- R11: With no strobe acted on and `advance_n` high, `array_addr_o` and `active_o` hold, and `burst_start_o` is 0.
- R12: While `active_o` is 0, a low `advance_n` without a strobe leaves `array_addr_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_i | input | 17 | Word address sampled by an accepted strobe |
| strobe_cpu_n | input | 1 | Processor address strobe, active low, highest priority |
| strobe_ctl_n | input | 1 | Controller address strobe, active low |
| advance_n | input | 1 | Burst advance, active low |
| ce_a_n | input | 1 | Chip enable, active low; also gates the processor strobe |
| ce_b | input | 1 | Chip enable, active high |
| ce_c_n | input | 1 | Chip enable, active low |
| order_sel | input | 1 | Static burst order: 1 interleaved (XOR), 0 linear |
| array_addr_o | output | 17 | Current array word address |
| active_o | output | 1 | Block selected by the last strobe acted on |
| burst_start_o | output | 1 | First address of a newly loaded burst |
| cpu_src_o | output | 1 | Last load came from the processor strobe |

## Verification
The bound checker tests several relations on every cycle: strobe priority and the gating by the first enable, deselection, loading including an advance that arrives in the load cycle, holding, stepping with fixed upper bits, and freezing while deselected. The exact order of the low bits across a burst, wraparound after four beats, and the difference between the linear and interleaved walks for a given start value can only be shown by the bench. Its behavioural model compares every output on every clock through those scenarios.

// File: rtl/burst_pkg.sv
package burst_pkg;

    typedef enum logic [1:0] {
        ACT_HOLD     = 2'd0,
        ACT_LOAD_CPU = 2'd1,
        ACT_LOAD_CTL = 2'd2,
        ACT_DESEL    = 2'd3
    } strobe_act_e;

endpackage

// File: rtl/burst_strobe_decode.sv
module burst_strobe_decode
    import burst_pkg::*;
(
    input  logic        strobe_cpu_n,
    input  logic        strobe_ctl_n,
    input  logic        ce_a_n,
    input  logic        ce_b,
    input  logic        ce_c_n,
    output strobe_act_e act_o
);

    logic cpu_taken;
    logic ctl_taken;
    logic enables_ok;

    always_comb begin
        // processor strobe only counts while the first enable is active
        cpu_taken  = !strobe_cpu_n && !ce_a_n;
        ctl_taken  = !strobe_ctl_n && !cpu_taken;
        enables_ok = !ce_a_n && ce_b && !ce_c_n;
        act_o      = ACT_HOLD;
        if (cpu_taken || ctl_taken) begin
            if (!enables_ok) begin
                act_o = ACT_DESEL;
            end else if (cpu_taken) begin
                act_o = ACT_LOAD_CPU;
            end else begin
                act_o = ACT_LOAD_CTL;
            end
        end
    end

endmodule

// File: rtl/burst_seq_counter.sv
module burst_seq_counter #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] start_i,
    input  logic             step_i,
    input  logic             order_sel,
    output logic [CNT_W-1:0] low_o
);

    typedef struct packed {
        logic [CNT_W-1:0] start;
        logic [CNT_W-1:0] count;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    logic [CNT_W-1:0] lin_low;
    logic [CNT_W-1:0] xor_low;

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.start = start_i;
            st_d.count = '0;
        end else if (step_i) begin
            st_d.count = st_q.count + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // per-bit walk builders: wrap is implicit in the CNT_W-bit width
    assign lin_low = st_q.start + st_q.count;
    for (genvar b = 0; b < CNT_W; b++) begin : g_xor
        assign xor_low[b] = st_q.start[b] ^ st_q.count[b];
    end

    assign low_o = order_sel ? xor_low : lin_low;

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import burst_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int CNT_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              strobe_cpu_n,
    input  logic              strobe_ctl_n,
    input  logic              advance_n,
    input  logic              ce_a_n,
    input  logic              ce_b,
    input  logic              ce_c_n,
    input  logic              order_sel,
    output logic [ADDR_W-1:0] array_addr_o,
    output logic              active_o,
    output logic              burst_start_o,
    output logic              cpu_src_o
);

    localparam int UP_W = ADDR_W - CNT_W;

    typedef struct packed {
        logic [UP_W-1:0] upper;
        logic            active;
        logic            bstart;
        logic            src_cpu;
    } gen_state_t;

    gen_state_t  st_d, st_q;
    strobe_act_e act;
    logic        do_load;
    logic        do_step;
    logic [CNT_W-1:0] low;

    burst_strobe_decode u_dec (
        .strobe_cpu_n (strobe_cpu_n),
        .strobe_ctl_n (strobe_ctl_n),
        .ce_a_n       (ce_a_n),
        .ce_b         (ce_b),
        .ce_c_n       (ce_c_n),
        .act_o        (act)
    );

    always_comb begin
        st_d    = st_q;
        do_load = 1'b0;
        do_step = 1'b0;
        st_d.bstart = 1'b0;
        case (act)
            ACT_LOAD_CPU, ACT_LOAD_CTL: begin
                do_load      = 1'b1;
                st_d.upper   = addr_i[ADDR_W-1:CNT_W];
                st_d.active  = 1'b1;
                st_d.bstart  = 1'b1;
                st_d.src_cpu = (act == ACT_LOAD_CPU);
            end
            ACT_DESEL: begin
                st_d.active = 1'b0;
            end
            default: begin
                do_step = !advance_n && st_q.active;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    burst_seq_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (do_load),
        .start_i   (addr_i[CNT_W-1:0]),
        .step_i    (do_step),
        .order_sel (order_sel),
        .low_o     (low)
    );

    assign array_addr_o  = {st_q.upper, low};
    assign active_o      = st_q.active;
    assign burst_start_o = st_q.bstart;
    assign cpu_src_o     = st_q.src_cpu;

endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
    parameter int ADDR_W = 17,
    parameter int CNT_W  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr_i,
    input logic              strobe_cpu_n,
    input logic              strobe_ctl_n,
    input logic              advance_n,
    input logic              ce_a_n,
    input logic              ce_b,
    input logic              ce_c_n,
    input logic              order_sel,
    input logic [ADDR_W-1:0] array_addr_o,
    input logic              active_o,
    input logic              burst_start_o,
    input logic              cpu_src_o
);

    logic all_en;
    logic no_strobe;
    assign all_en    = !ce_a_n && ce_b && !ce_c_n;
    assign no_strobe = (strobe_cpu_n || ce_a_n) && strobe_ctl_n;

    a_r2_cpu_load: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe_cpu_n && all_en) |=>
        (array_addr_o == $past(addr_i) && active_o && burst_start_o && cpu_src_o));

    a_r3_cpu_priority: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe_cpu_n && !strobe_ctl_n && all_en) |=> cpu_src_o);

    a_r4_cpu_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe_cpu_n && ce_a_n && !strobe_ctl_n) |=> (!active_o && !burst_start_o));

    a_r5_deselect: assert property (@(posedge clk) disable iff (!rst_n)
        (!no_strobe && !all_en) |=> (!active_o && $stable(array_addr_o) && $stable(cpu_src_o)));

    a_r7_adv_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (!no_strobe && all_en && !advance_n) |=>
        (array_addr_o[CNT_W-1:0] == $past(addr_i[CNT_W-1:0])));

    a_r6_step: assert property (@(posedge clk) disable iff (!rst_n)
        (no_strobe && !advance_n && active_o) |=>
        ((order_sel != $past(order_sel)) ||
         (array_addr_o[CNT_W-1:0] != $past(array_addr_o[CNT_W-1:0]))));

    a_r10_upper_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        no_strobe |=> $stable(array_addr_o[ADDR_W-1:CNT_W]));

    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (no_strobe && advance_n) |=>
        (!burst_start_o && $stable(active_o) &&
         ((order_sel != $past(order_sel)) || $stable(array_addr_o))));

    a_r12_frozen_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (no_strobe && !active_o) |=>
        (!active_o && ((order_sel != $past(order_sel)) || $stable(array_addr_o))));

endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .addr_i        (addr_i),
    .strobe_cpu_n  (strobe_cpu_n),
    .strobe_ctl_n  (strobe_ctl_n),
    .advance_n     (advance_n),
    .ce_a_n        (ce_a_n),
    .ce_b          (ce_b),
    .ce_c_n        (ce_c_n),
    .order_sel     (order_sel),
    .array_addr_o  (array_addr_o),
    .active_o      (active_o),
    .burst_start_o (burst_start_o),
    .cpu_src_o     (cpu_src_o)
);

// File: tb/burst_addr_gen_test.sv
module burst_addr_gen_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [16:0] addr_i = '0;
    logic        strobe_cpu_n = 1'b1;
    logic        strobe_ctl_n = 1'b1;
    logic        advance_n = 1'b1;
    logic        ce_a_n = 1'b0;
    logic        ce_b = 1'b1;
    logic        ce_c_n = 1'b0;
    logic        order_sel = 1'b1;
    logic [16:0] array_addr_o;
    logic        active_o;
    logic        burst_start_o;
    logic        cpu_src_o;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // reference model state
    int m_upper = 0;
    int m_start = 0;
    int m_step = 0;
    bit m_active = 0;
    bit m_bstart = 0;
    bit m_src = 0;

    always #5 clk = ~clk;

    burst_addr_gen uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .addr_i        (addr_i),
        .strobe_cpu_n  (strobe_cpu_n),
        .strobe_ctl_n  (strobe_ctl_n),
        .advance_n     (advance_n),
        .ce_a_n        (ce_a_n),
        .ce_b          (ce_b),
        .ce_c_n        (ce_c_n),
        .order_sel     (order_sel),
        .array_addr_o  (array_addr_o),
        .active_o      (active_o),
        .burst_start_o (burst_start_o),
        .cpu_src_o     (cpu_src_o)
    );

    function automatic int model_addr();
        int low;
        if (order_sel) low = m_start ^ m_step;
        else           low = (m_start + m_step) % 4;
        return m_upper * 4 + low;
    endfunction

    task automatic check_all(input string tag);
        int exp_addr;
        exp_addr = model_addr();
        checks++;
        if (int'(array_addr_o) != exp_addr || active_o != m_active ||
            burst_start_o != m_bstart || cpu_src_o != m_src) begin
            failures++;
            $display("FAIL %s: addr=%05h act=%0b start=%0b src=%0b expected addr=%05h act=%0b start=%0b src=%0b",
                     tag, array_addr_o, active_o, burst_start_o, cpu_src_o,
                     exp_addr, m_active, m_bstart, m_src);
        end
    endtask

    task automatic cyc(input bit cpu_n, input bit ctl_n, input bit adv_n,
                       input bit a_n, input bit b, input bit c_n,
                       input logic [16:0] a, input string tag);
        bit cpu_ok;
        bit take;
        strobe_cpu_n = cpu_n;
        strobe_ctl_n = ctl_n;
        advance_n    = adv_n;
        ce_a_n       = a_n;
        ce_b         = b;
        ce_c_n       = c_n;
        addr_i       = a;
        @(posedge clk);
        cpu_ok = !cpu_n && !a_n;
        take   = cpu_ok || !ctl_n;
        if (take) begin
            if (!a_n && b && !c_n) begin
                m_upper  = int'(a) / 4;
                m_start  = int'(a) % 4;
                m_step   = 0;
                m_active = 1;
                m_bstart = 1;
                m_src    = cpu_ok;
            end else begin
                m_active = 0;
                m_bstart = 0;
            end
        end else begin
            m_bstart = 0;
            if (!adv_n && m_active) m_step = (m_step + 1) % 4;
        end
        #2;
        check_all(tag);
    endtask

    task automatic idle(input bit adv_n, input string tag);
        cyc(1, 1, adv_n, 0, 1, 0, 17'h0, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        #2;
        check_all("R1 during reset");
        @(negedge clk);
        rst_n = 1'b1;
        idle(1, "R1 after reset");

        // R2, R9, R6, R10: processor load, interleaved walk, start 01
        order_sel = 1'b1;
        cyc(0, 1, 1, 0, 1, 0, 17'h1_2345, "R2 cpu load");
        for (int i = 0; i < 4; i++) idle(0, "R9 interleaved step / R10 upper");
        idle(0, "R6 wrap continue");
        // R11: hold
        idle(1, "R11 hold");
        idle(1, "R11 hold");

        // R7: advance in load cycle, start 10 interleaved
        cyc(0, 1, 0, 0, 1, 0, 17'h0_ABCE, "R7 adv ignored on load");
        for (int i = 0; i < 4; i++) idle(0, "R9 interleaved start 10");

        // R8: linear order, start 10 and start 11
        order_sel = 1'b0;
        cyc(1, 0, 1, 0, 1, 0, 17'h1_FFFE, "R8 ctl load linear");
        for (int i = 0; i < 5; i++) idle(0, "R8 linear step / R6 wrap");
        cyc(0, 1, 1, 0, 1, 0, 17'h0_0013, "R8 load start 11");
        for (int i = 0; i < 3; i++) idle(0, "R8 linear start 11");

        // R3: both strobes low, processor wins
        cyc(1, 0, 1, 0, 1, 0, 17'h0_5550, "R3 ctl only src=0");
        cyc(0, 0, 1, 0, 1, 0, 17'h0_AAA1, "R3 both low src=1");

        // R4: processor strobe gated by first enable
        order_sel = 1'b1;
        idle(0, "R4 setup step");
        cyc(0, 1, 1, 1, 1, 0, 17'h1_0000, "R4 cpu ignored hold");
        cyc(0, 1, 0, 1, 1, 0, 17'h1_0000, "R4 cpu ignored adv steps");
        cyc(0, 0, 1, 1, 1, 0, 17'h1_0000, "R4 ctl acted deselect");

        // R12: advance while deselected
        idle(0, "R12 frozen");
        idle(0, "R12 frozen");

        // R5: deselect variants
        cyc(0, 1, 1, 0, 1, 0, 17'h0_7777, "R5 reload");
        cyc(1, 0, 1, 0, 0, 0, 17'h1_1111, "R5 ctl with ce_b low");
        cyc(0, 1, 1, 0, 1, 0, 17'h0_3332, "R5 reload");
        cyc(0, 1, 1, 0, 1, 1, 17'h1_1111, "R5 cpu with ce_c_n high");
        idle(0, "R12 frozen after deselect");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule